// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the serial test register that sits between a core and its device pads. Every input pad and every output pad gets one scan cell. The cells are linked into a single shift path that starts at the serial test input `tdi` and ends at the serial test output `tdo`.

A test access port controller sequences the chain with three strobes: capture, shift and update. It also supplies a two-bit mode code. Each cell contains three parts:

- a shift stage clocked on the rising test-clock edge;
- a hold latch loaded on the falling edge;
- a selector that chooses between the functional signal and the held value.

In the interconnect-test mode, the held values drive the output pads while the input pads are observed. In the core-test mode, the held values drive the core inputs while the core outputs are observed. In the pass modes, the functional signals flow through untouched, but the chain can still sample and preload.

The pad counts are parameters. The chain length is their sum. `tdo` shows the shift stage of the last output cell directly; any retiming onto the falling edge belongs to the controller.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds IN_PINS + OUT_PINS stages, ordered from `tdi` through input cells 0..IN_PINS-1 and then output cells 0..OUT_PINS-1. `tdo` is the stage of the last output cell. A bit entered at `tdi` therefore first shows on `tdo` after exactly IN_PINS + OUT_PINS shifting edges.
- R2: On a rising `tck` edge with `shift_dr` high and `capture_dr` low, every stage takes the value of its upstream neighbour, and the first stage takes `tdi`.
- R3: On a rising `tck` edge with `capture_dr` high, input cells load `pin_in` and output cells load `core_out`. Capture takes priority over a simultaneous shift.
- R4: On a rising `tck` edge with both `capture_dr` and `shift_dr` low, all shift stages keep their values.
- R5: On a falling `tck` edge with `update_dr` high, each hold latch copies its shift stage. With `update_dr` low the latches keep their value, so driven values do not change while data shifts.
- R6: With `mode` = 2'b00 or 2'b11 (pass), `pin_out` equals `core_out` and `core_in` equals `pin_in`, combinationally.
- R7: With `mode` = 2'b01 (interconnect test), `pin_out` bit j is the hold latch of output cell j, and `core_in` still equals `pin_in`.
- R8: With `mode` = 2'b10 (core test), `core_in` bit i is the hold latch of input cell i, and `pin_out` still equals `core_out`.
- R9: `trst_n` low clears all shift stages and hold latches to 0 at once, without waiting for a clock, so `tdo` reads 0.
- R10: In pass mode, values can be shifted in and updated without disturbing the functional outputs. A later switch to mode 2'b01 drives the preloaded values onto `pin_out` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| capture_dr | input | 1 | Parallel load of the shift stages |
| shift_dr | input | 1 | Serial advance of the chain |
| update_dr | input | 1 | Transfer of shift stages into hold latches (falling edge) |
| mode | input | 2 | 00/11 pass, 01 interconnect test, 10 core test |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| pin_in | input | IN_PINS | Values arriving at the input pads |
| core_in | output | IN_PINS | Values delivered to the core inputs |
| core_out | input | OUT_PINS | Values produced by the core outputs |
| pin_out | output | OUT_PINS | Values driven to the output pads |

## Verification
The embedded properties watch four things on every clock:

- the pass-through in the pass modes;
- the input-side pass-through during interconnect test;
- capture of the last core output onto `tdo`;
- `tdo` holding when no strobe is given, plus the stability of each hold latch across falling edges without an update.

End-to-end order and length of the chain need the bench's scenarios: a walking one counted out over exactly IN_PINS + OUT_PINS shifts, a preload followed by a mode switch, and seeded random mixes of strobes and modes compared against a bench model of every stage and latch. Asynchronous reset in the middle of a run is also shown only there.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   // Test mode code supplied by the port controller.
   typedef enum logic [1:0] {
      BSR_PASS       = 2'b00,
      BSR_DRIVE_PINS = 2'b01,
      BSR_DRIVE_CORE = 2'b10,
      BSR_PASS_ALT   = 2'b11
   } bsr_mode_e;

   // Minimum legal pad count on either side.
   localparam int unsigned BSR_MIN_PINS = 1;

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit FALL_UPDATE = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic capture_en,
   input  logic shift_en,
   input  logic update_en,
   input  logic force_sel,
   input  logic par_in,
   input  logic ser_in,
   output logic ser_out,
   output logic par_out
);

   logic stage_q;
   logic hold_q;

   // Shift stage: capture outranks shift, otherwise hold.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         stage_q <= 1'b0;
      else if (capture_en) stage_q <= par_in;
      else if (shift_en)   stage_q <= ser_in;
   end

   generate
      if (FALL_UPDATE) begin : g_fall_update
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n)        hold_q <= 1'b0;
            else if (update_en) hold_q <= stage_q;
         end

         // R5
         latch_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
            !update_en |=> $stable(hold_q));
      end else begin : g_rise_update
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)        hold_q <= 1'b0;
            else if (update_en) hold_q <= stage_q;
         end

         // R5
         latch_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
            !update_en |=> $stable(hold_q));
      end
   endgenerate

   assign ser_out = stage_q;
   assign par_out = force_sel ? hold_q : par_in;

endmodule

// File: rtl/bsr_segment.sv
module bsr_segment #(
   parameter int unsigned WIDTH       = 4,
   parameter bit          FALL_UPDATE = 1'b1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             capture_en,
   input  logic             shift_en,
   input  logic             update_en,
   input  logic             force_sel,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] par_out,
   output logic             ser_out
);

   localparam int unsigned LINKS = WIDTH + 1;

   logic [LINKS-1:0] link;

   assign link[0] = ser_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         bsr_cell #(
            .FALL_UPDATE (FALL_UPDATE)
         ) u_cell (
            .tck        (tck),
            .trst_n     (trst_n),
            .capture_en (capture_en),
            .shift_en   (shift_en),
            .update_en  (update_en),
            .force_sel  (force_sel),
            .par_in     (par_in[i]),
            .ser_in     (link[i]),
            .ser_out    (link[i+1]),
            .par_out    (par_out[i])
         );
      end
   endgenerate

   assign ser_out = link[LINKS-1];

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int unsigned IN_PINS     = 5,
   parameter int unsigned OUT_PINS    = 3,
   parameter bit          FALL_UPDATE = 1'b1
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic [1:0]          mode,
   input  logic                tdi,
   output logic                tdo,
   input  logic [IN_PINS-1:0]  pin_in,
   output logic [IN_PINS-1:0]  core_in,
   input  logic [OUT_PINS-1:0] core_out,
   output logic [OUT_PINS-1:0] pin_out
);

   localparam int unsigned CHAIN_LEN = IN_PINS + OUT_PINS;
   localparam int unsigned LAST_OUT  = OUT_PINS - 1;

   generate
      if (IN_PINS < BSR_MIN_PINS || OUT_PINS < BSR_MIN_PINS) begin : g_bad_pins
         $error("bsr_chain: each side needs at least one pad");
      end
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("bsr_chain: chain too short");
      end
   endgenerate

   bsr_mode_e mode_q;
   logic      drive_pins;
   logic      drive_core;
   logic      mid_link;

   assign mode_q     = bsr_mode_e'(mode);
   assign drive_pins = (mode_q == BSR_DRIVE_PINS);
   assign drive_core = (mode_q == BSR_DRIVE_CORE);

   // Input pads come first after tdi.
   bsr_segment #(
      .WIDTH       (IN_PINS),
      .FALL_UPDATE (FALL_UPDATE)
   ) u_in_seg (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_dr),
      .shift_en   (shift_dr),
      .update_en  (update_dr),
      .force_sel  (drive_core),
      .par_in     (pin_in),
      .ser_in     (tdi),
      .par_out    (core_in),
      .ser_out    (mid_link)
   );

   // Output pads follow; the last one faces tdo.
   bsr_segment #(
      .WIDTH       (OUT_PINS),
      .FALL_UPDATE (FALL_UPDATE)
   ) u_out_seg (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_dr),
      .shift_en   (shift_dr),
      .update_en  (update_dr),
      .force_sel  (drive_pins),
      .par_in     (core_out),
      .ser_in     (mid_link),
      .par_out    (pin_out),
      .ser_out    (tdo)
   );

   // R6
   pass_through_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 2'b00 || mode == 2'b11) |-> (pin_out == core_out && core_in == pin_in));

   // R7
   extest_core_side_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 2'b01) |-> (core_in == pin_in));

   // R8
   intest_pin_side_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 2'b10) |-> (pin_out == core_out));

   // R3
   capture_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> (tdo == $past(core_out[LAST_OUT])));

   // R4
   hold_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!capture_dr && !shift_dr) |=> $stable(tdo));

   // R9
   always @(posedge tck) begin
      if (!trst_n) begin
         reset_tdo_chk: assert (tdo == 1'b0);
      end
   end

endmodule

// File: tb/bsr_chain_bench.sv
`timescale 1ns/1ps
module bsr_chain_bench;

   localparam int NI = 5;
   localparam int NO = 3;
   localparam int L  = NI + NO;

   logic          tck = 1'b0;
   logic          trst_n;
   logic          capture_dr, shift_dr, update_dr;
   logic [1:0]    mode;
   logic          tdi;
   logic          tdo;
   logic [NI-1:0] pin_in;
   logic [NI-1:0] core_in;
   logic [NO-1:0] core_out;
   logic [NO-1:0] pin_out;

   int chk_cnt  = 0;
   int fail_cnt = 0;

   // Model: index 0 is next to tdi, index L-1 faces tdo.
   logic [L-1:0] m_sh;
   logic [L-1:0] m_up;

   always #2 tck = ~tck;

   bsr_chain #(.IN_PINS(NI), .OUT_PINS(NO)) u_bsr_chain (
      .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .mode(mode), .tdi(tdi), .tdo(tdo),
      .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      chk_cnt++;
      if (act !== exp) begin
         fail_cnt++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [NO-1:0] exp_pin_out();
      return (mode == 2'b01) ? m_up[L-1:NI] : core_out;
   endfunction

   function automatic logic [NI-1:0] exp_core_in();
      return (mode == 2'b10) ? m_up[NI-1:0] : pin_in;
   endfunction

   function automatic string side_tag();
      case (mode)
         2'b01:   return "R7";
         2'b10:   return "R8";
         default: return "R6";
      endcase
   endfunction

   task automatic check_ports(input string tdo_tag);
      chk(tdo_tag, 64'(tdo), 64'(m_sh[L-1]));
      chk(side_tag(), 64'(pin_out), 64'(exp_pin_out()));
      chk(side_tag(), 64'(core_in), 64'(exp_core_in()));
   endtask

   // Called one ns after a rising edge; returns one ns after the next.
   task automatic tick(input logic cap, input logic sh, input logic up, input logic din);
      capture_dr = cap; shift_dr = sh; update_dr = up; tdi = din;
      @(negedge tck);
      if (up) m_up = m_sh;
      @(posedge tck);
      if (cap)     m_sh = {core_out, pin_in};
      else if (sh) m_sh = {m_sh[L-2:0], din};
      #1;
   endtask

   initial begin
      #400000;
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
      $finish;
   end

   initial begin
      logic [L-1:0] pattern;
      logic [NO-1:0] held;
      void'($urandom(32'd1149));
      trst_n = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
      mode = 2'b01; tdi = 1'b0; pin_in = '0; core_out = 3'b101;
      m_sh = '0; m_up = '0;
      repeat (3) @(posedge tck);
      #1;
      // R9: reset state on both driven sides
      chk("R9", 64'(tdo), 64'd0);
      chk("R9", 64'(pin_out), 64'd0);
      mode = 2'b10; pin_in = 5'b11011; #0.5;
      chk("R9", 64'(core_in), 64'd0);
      trst_n = 1'b1;
      @(posedge tck); #1;

      // R1: walking one appears after exactly L shifts
      mode = 2'b00;
      for (int k = 1; k <= L; k++) begin
         tick(1'b0, 1'b1, 1'b0, (k == 1));
         chk("R1", 64'(tdo), (k == L) ? 64'd1 : 64'd0);
      end

      // R3: capture wins over a simultaneous shift
      core_out = 3'b100; pin_in = 5'b01010;
      tick(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R3", 64'(tdo), 64'd1);
      check_ports("R3");
      // R4: no strobe keeps tdo
      tick(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R4", 64'(tdo), 64'd1);

      // R10: preload in pass mode, then switch to interconnect test
      pattern = L'($urandom);
      for (int k = L - 1; k >= 0; k--) begin
         tick(1'b0, 1'b1, 1'b0, pattern[k]);
         chk("R10", 64'(pin_out), 64'(core_out));
      end
      tick(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R10", 64'(pin_out), 64'(core_out));
      mode = 2'b01; #0.5;
      chk("R10", 64'(pin_out), 64'(pattern[L-1:NI]));
      #0.5;

      // R5: shifting without update leaves driven pads alone
      held = pin_out;
      for (int k = 0; k < L; k++) begin
         tick(1'b0, 1'b1, 1'b0, 1'($urandom));
         chk("R5", 64'(pin_out), 64'(held));
      end

      // Seeded random mix checked against the model
      for (int n = 0; n < 600; n++) begin
         mode     = 2'($urandom);
         pin_in   = NI'($urandom);
         core_out = NO'($urandom);
         tick(($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0, 1'($urandom));
         check_ports("R2");
      end

      // R9: asynchronous reset in the middle of a run
      mode = 2'b01;
      tick(1'b0, 1'b0, 1'b1, 1'b0);
      trst_n = 1'b0; m_sh = '0; m_up = '0; #0.5;
      chk("R9", 64'(tdo), 64'd0);
      chk("R9", 64'(pin_out), 64'd0);
      @(posedge tck); #1;
      trst_n = 1'b1;
      @(posedge tck); #1;
      check_ports("R9");

      $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
      $finish;
   end

endmodule